// File: doc/BRIEF.md
# Saturating BIP-8 Error Counter

This block monitors the byte-interleaved parity byte carried in a SONET/SDH overhead position. Each clock it takes one byte of the received stream, together with a strobe for the first byte of each frame, a flag for bytes that fall inside the parity coverage, and a flag for the byte that carries the transmitted parity. It forms the even parity of every covered byte of one frame and, in the frame that follows, compares that parity with the received parity byte.

Each mismatch feeds an error counter. In bit mode the counter grows by the number of differing parity bits. In block mode it grows by one for each errored frame. The counter holds a full second of worst-case errors and sticks at its ceiling instead of wrapping. Software reads it through a read-and-clear strobe that returns the current value and empties the counter without losing an error that lands in the same cycle. The same structure serves the line remote-error count. A one-cycle strobe marks each errored frame.

Top module: `bip8_err_counter`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `err_count` is 0 and `err_strobe` is 0.
- R2: The reference parity of a frame is the bitwise XOR of the bytes presented with `cover_en` = 1 from its `frame_start` cycle up to the next `frame_start`. Bytes with `cover_en` = 0 have no effect on it.
- R3: The counter saturates at 2^CNT_W - 1 (131071 by default) and stays there under further errors until cleared.
- R4: With `block_mode` = 0, a mismatching parity byte adds the number of bit positions in which it differs from the reference (1 to 8).
- R5: With `block_mode` = 1, a mismatching parity byte adds exactly 1, whatever the number of differing bits.
- R6: While `rd_clr` is high, `err_count` shows the accumulated value. At the next edge the counter becomes 0, or becomes the contribution of an error compared in that same cycle.
- R7: No comparison is made until one complete frame has been seen. In the first frame after reset, a parity byte never counts or strobes.
- R8: `err_strobe` is high for exactly the one cycle after a mismatching parity byte. It stays low after a matching one, and `err_count` does not change without an error or a clear.
- R9: Only the first byte flagged by `parity_en` in a frame is compared. Later flagged bytes in the same frame are ignored.
- R10: At the default width the counter reaches exactly 64000 after 8000 frames of 8 bit errors each, with no saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_byte | input | 8 | Received byte stream, one byte per cycle |
| frame_start | input | 1 | High on the first byte of each frame |
| cover_en | input | 1 | Byte is inside the parity coverage |
| parity_en | input | 1 | Byte is the received parity byte |
| block_mode | input | 1 | 0 = count errored bits, 1 = count errored frames |
| rd_clr | input | 1 | Read-and-clear strobe |
| err_count | output | CNT_W | Accumulated error count |
| err_strobe | output | 1 | One-cycle pulse per errored frame |

## Verification
On every cycle, the checker enforces several rules. The count must hold still when no error strobe or clear occurs. A step must be 1 to 8 in bit mode and exactly 1 in block mode. A saturated count must stay at its ceiling. A clear must leave 0 or only the contribution of a coinciding error. The bench's frame-level scenarios are needed for the rest: that the reference really is the XOR of the covered bytes of the previous frame, that uncovered bytes and second parity bytes are ignored, that the first frame after reset is never compared, and that saturation is reached after the expected number of errored frames.

// File: rtl/bip8_pkg.sv
package bip8_pkg;

    localparam int BIP_W    = 8;
    localparam int WEIGHT_W = $clog2(BIP_W + 1);

    typedef enum logic {
        CNT_BIT   = 1'b0,
        CNT_BLOCK = 1'b1
    } cnt_mode_e;

    typedef struct packed {
        logic                hit;
        logic [WEIGHT_W-1:0] weight;
    } err_event_t;

    function automatic logic [WEIGHT_W-1:0] ones_in(input logic [BIP_W-1:0] v);
        logic [WEIGHT_W-1:0] n;
        n = '0;
        for (int i = 0; i < BIP_W; i++) begin
            n = n + WEIGHT_W'(v[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/bip8_parity_acc.sv
module bip8_parity_acc
    import bip8_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [BIP_W-1:0] data,
    input  logic             frame_start,
    input  logic             cover_en,
    output logic [BIP_W-1:0] ref_par,
    output logic             ref_valid
);

    logic [BIP_W-1:0] acc_q;
    logic [BIP_W-1:0] ref_q;
    logic             ref_vld_q;
    logic             seen_start_q;
    logic [BIP_W-1:0] cov_byte;

    assign cov_byte = cover_en ? data : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q        <= '0;
            ref_q        <= '0;
            ref_vld_q    <= 1'b0;
            seen_start_q <= 1'b0;
        end else if (frame_start) begin
            acc_q        <= cov_byte;
            ref_q        <= acc_q;
            ref_vld_q    <= seen_start_q;
            seen_start_q <= 1'b1;
        end else begin
            acc_q <= acc_q ^ cov_byte;
        end
    end

    // A parity byte coinciding with frame_start is judged against the frame just closed.
    assign ref_par   = frame_start ? acc_q        : ref_q;
    assign ref_valid = frame_start ? seen_start_q : ref_vld_q;

endmodule

// File: rtl/bip8_compare.sv
module bip8_compare
    import bip8_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [BIP_W-1:0] data,
    input  logic             frame_start,
    input  logic             parity_en,
    input  logic [BIP_W-1:0] ref_par,
    input  logic             ref_valid,
    input  cnt_mode_e        mode,
    output err_event_t       ev
);

    logic             checked_q;
    logic             first_par;
    logic             do_cmp;
    logic [BIP_W-1:0] diff;

    assign first_par = parity_en & (frame_start | ~checked_q);
    assign do_cmp    = first_par & ref_valid;
    assign diff      = data ^ ref_par;

    always_ff @(posedge clk) begin
        if (rst) begin
            checked_q <= 1'b0;
        end else if (frame_start) begin
            checked_q <= parity_en;
        end else if (parity_en) begin
            checked_q <= 1'b1;
        end
    end

    always_comb begin
        ev = '0;
        if (do_cmp && (diff != '0)) begin
            ev.hit    = 1'b1;
            ev.weight = (mode == CNT_BLOCK) ? WEIGHT_W'(1) : ones_in(diff);
        end
    end

endmodule

// File: rtl/bip8_sat_counter.sv
module bip8_sat_counter #(
    parameter int CNT_W = 17,
    parameter int INC_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [INC_W-1:0] inc,
    input  logic             rd_clr,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] base;
    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] nxt;

    always_comb begin
        base = rd_clr ? '0 : cnt_q;
        sum  = {1'b0, base} + {{(CNT_W + 1 - INC_W){1'b0}}, inc};
        nxt  = sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= nxt;
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/bip8_err_counter.sv
module bip8_err_counter
    import bip8_pkg::*;
#(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       rx_byte,
    input  logic             frame_start,
    input  logic             cover_en,
    input  logic             parity_en,
    input  logic             block_mode,
    input  logic             rd_clr,
    output logic [CNT_W-1:0] err_count,
    output logic             err_strobe
);

    logic [BIP_W-1:0]    ref_par;
    logic                ref_valid;
    err_event_t          ev;
    cnt_mode_e           mode;
    logic [WEIGHT_W-1:0] inc;
    logic                strobe_q;

    assign mode = block_mode ? CNT_BLOCK : CNT_BIT;

    bip8_parity_acc u_acc (
        .clk         (clk),
        .rst         (rst),
        .data        (rx_byte),
        .frame_start (frame_start),
        .cover_en    (cover_en),
        .ref_par     (ref_par),
        .ref_valid   (ref_valid)
    );

    bip8_compare u_cmp (
        .clk         (clk),
        .rst         (rst),
        .data        (rx_byte),
        .frame_start (frame_start),
        .parity_en   (parity_en),
        .ref_par     (ref_par),
        .ref_valid   (ref_valid),
        .mode        (mode),
        .ev          (ev)
    );

    assign inc = ev.weight;

    bip8_sat_counter #(
        .CNT_W (CNT_W),
        .INC_W (WEIGHT_W)
    ) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .inc    (inc),
        .rd_clr (rd_clr),
        .count  (err_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= ev.hit;
        end
    end

    assign err_strobe = strobe_q;

endmodule

// File: rtl/bip8_err_counter_chk.sv
module bip8_err_counter_chk #(
    parameter int CNT_W = 17
) (
    input logic             clk,
    input logic             rst,
    input logic             block_mode,
    input logic             rd_clr,
    input logic [CNT_W-1:0] err_count,
    input logic             err_strobe
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             past_ok = 1'b0;
    logic             rst_d   = 1'b0;
    logic             rd_d    = 1'b0;
    logic             blk_d   = 1'b0;
    logic [CNT_W-1:0] cnt_d   = '0;

    always_ff @(posedge clk) begin
        past_ok <= ~rst;
        rst_d   <= rst;
        rd_d    <= rd_clr;
        blk_d   <= block_mode;
        cnt_d   <= err_count;
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        rst_d |-> (err_count == '0) && !err_strobe)
        else $error("R1 state not cleared by reset");

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !rd_d && cnt_d == CNT_MAX) |-> err_count == CNT_MAX)
        else $error("R3 counter left saturation");

    p_bit_step_r4: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !rd_d && err_strobe && !blk_d && cnt_d != CNT_MAX) |->
        (err_count > cnt_d) && ((err_count - cnt_d) <= CNT_W'(8)))
        else $error("R4 bit-mode step out of range");

    p_block_step_r5: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !rd_d && err_strobe && blk_d && cnt_d != CNT_MAX) |->
        err_count == cnt_d + CNT_W'(1))
        else $error("R5 block-mode step not one");

    p_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (past_ok && rd_d) |->
        (err_strobe ? ((err_count >= CNT_W'(1)) && (err_count <= CNT_W'(8)))
                    : (err_count == '0)))
        else $error("R6 read-clear result wrong");

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !rd_d && !err_strobe) |-> err_count == cnt_d)
        else $error("R8 count moved without error");

endmodule

bind bip8_err_counter bip8_err_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .block_mode (block_mode),
    .rd_clr     (rd_clr),
    .err_count  (err_count),
    .err_strobe (err_strobe)
);

// File: tb/tb_bip8_err_counter.sv
module tb_bip8_err_counter;

    localparam int CNT_W = 17;
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic        blk;
        logic [31:0] cov;
        logic [7:0]  mask;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 32'h1234_5678, 8'h00},
        '{1'b0, 32'hDEAD_BEEF, 8'h01},
        '{1'b0, 32'h0000_0000, 8'h80},
        '{1'b0, 32'hFFFF_FFFF, 8'hFF},
        '{1'b1, 32'hA5A5_5A5A, 8'h0F},
        '{1'b1, 32'h0102_0408, 8'h00},
        '{1'b1, 32'hCAFE_F00D, 8'h3C},
        '{1'b0, 32'h7777_1111, 8'h3C},
        '{1'b0, 32'h8000_0001, 8'hAA},
        '{1'b1, 32'h55AA_55AA, 8'h01}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [7:0]       rx_byte = '0;
    logic             frame_start = 1'b0;
    logic             cover_en = 1'b0;
    logic             parity_en = 1'b0;
    logic             block_mode = 1'b0;
    logic             rd_clr = 1'b0;
    logic [CNT_W-1:0] err_count;
    logic             err_strobe;

    int total = 0;
    int bad   = 0;

    // bench model
    logic             m_started = 1'b0;
    logic             m_ref_ok  = 1'b0;
    logic [7:0]       m_ref     = '0;
    logic [7:0]       m_last    = '0;
    logic [CNT_W-1:0] m_cnt     = '0;
    logic             m_hit     = 1'b0;
    logic             seen_strobe;
    logic [CNT_W-1:0] seen_rd;

    always #4 clk = ~clk;

    bip8_err_counter #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .rx_byte(rx_byte), .frame_start(frame_start),
        .cover_en(cover_en), .parity_en(parity_en), .block_mode(block_mode),
        .rd_clr(rd_clr), .err_count(err_count), .err_strobe(err_strobe)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int ones(input logic [7:0] v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += v[i];
        return n;
    endfunction

    function automatic logic [CNT_W-1:0] sat(input logic [CNT_W-1:0] a, input int b);
        logic [CNT_W:0] s;
        s = {1'b0, a} + (CNT_W + 1)'(b);
        return s[CNT_W] ? CMAX : s[CNT_W-1:0];
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; frame_start = 0; cover_en = 0; parity_en = 0; rd_clr = 0;
        repeat (3) @(negedge clk);
        check("R1 count in reset", err_count, 0);
        check("R1 strobe in reset", err_strobe, 0);
        rst = 1'b0;
        m_started = 0; m_ref_ok = 0; m_ref = 0; m_last = 0; m_cnt = 0;
        @(negedge clk);
        check("R1 count after reset", err_count, 0);
    endtask

    // one frame: start+cov0, parity, cov1, cov2, cov3, tail byte, idle
    task automatic run_frame(input logic blk, input logic [31:0] cov, input logic [7:0] mask,
                             input logic par_en, input logic dup, input logic rc,
                             input logic [7:0] junk);
        logic [7:0] psent;
        int inc;
        if (m_started) begin m_ref_ok = 1; m_ref = m_last; end
        m_started = 1;
        psent = (m_ref_ok ? m_ref : 8'h00) ^ mask;
        m_hit = par_en && m_ref_ok && (mask != 0);
        inc   = blk ? 1 : ones(mask);
        if (rc) m_cnt = m_hit ? CNT_W'(inc) : '0;
        else if (m_hit) m_cnt = sat(m_cnt, inc);
        m_last = cov[7:0] ^ cov[15:8] ^ cov[23:16] ^ cov[31:24];

        @(negedge clk);
        block_mode = blk; frame_start = 1; cover_en = 1; rx_byte = cov[7:0];
        @(negedge clk);
        frame_start = 0; cover_en = 0; parity_en = par_en; rx_byte = psent; rd_clr = rc;
        seen_rd = err_count;
        @(negedge clk);
        seen_strobe = err_strobe;
        parity_en = 0; rd_clr = 0; cover_en = 1; rx_byte = cov[15:8];
        @(negedge clk);
        rx_byte = cov[23:16];
        @(negedge clk);
        rx_byte = cov[31:24];
        @(negedge clk);
        cover_en = 0; parity_en = dup; rx_byte = dup ? (psent ^ 8'hFF) : junk;
        @(negedge clk);
        parity_en = 0; rx_byte = 8'h00;
        @(negedge clk);
    endtask

    task automatic read_clear(input string tag);
        logic [CNT_W-1:0] v;
        @(negedge clk);
        rd_clr = 1; v = err_count;
        @(negedge clk);
        rd_clr = 0;
        check({tag, " read value"}, v, m_cnt);
        m_cnt = '0;
        check({tag, " cleared"}, err_count, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();

        // R7: first frame after reset never compared
        run_frame(1'b0, 32'h0F0F_0F0F, 8'hFF, 1'b1, 1'b0, 1'b0, 8'h00);
        check("R7 no strobe in first frame", seen_strobe, 0);
        check("R7 no count in first frame", err_count, 0);

        // table walk: R2 reference, R4 bit and R5 block modes, R8 strobe
        for (int i = 0; i < NV; i++) begin
            run_frame(VECS[i].blk, VECS[i].cov, VECS[i].mask, 1'b1, 1'b0, 1'b0, 8'h3C);
            check(VECS[i].blk ? "R5 block count" : "R4 bit count", err_count, m_cnt);
            check("R8 strobe per frame", seen_strobe, m_hit);
        end

        // R2: uncovered bytes do not disturb the reference
        run_frame(1'b0, 32'h1111_2222, 8'h00, 1'b1, 1'b0, 1'b0, 8'hFF);
        run_frame(1'b0, 32'h3333_4444, 8'h00, 1'b1, 1'b0, 1'b0, 8'h5A);
        check("R2 uncovered ignored strobe", seen_strobe, 0);
        check("R2 uncovered ignored count", err_count, m_cnt);

        // R9: second parity byte in a frame ignored
        run_frame(1'b0, 32'h9999_0000, 8'h00, 1'b1, 1'b1, 1'b0, 8'h00);
        check("R9 second parity ignored", err_count, m_cnt);

        // R6: plain read-clear, then clear coinciding with an error
        read_clear("R6");
        run_frame(1'b0, 32'h2468_ACE0, 8'h22, 1'b1, 1'b0, 1'b0, 8'h00);
        run_frame(1'b0, 32'h1357_9BDF, 8'h07, 1'b1, 1'b0, 1'b1, 8'h00);
        check("R6 value shown during clear", seen_rd, 2);
        check("R6 error kept across clear", err_count, 3);
        read_clear("R6 again");

        // R1: reset in mid-run clears, R7 applies again
        run_frame(1'b1, 32'h0, 8'h01, 1'b1, 1'b0, 1'b0, 8'h00);
        do_reset();
        run_frame(1'b1, 32'h4444_0000, 8'h01, 1'b1, 1'b0, 1'b0, 8'h00);
        check("R7 after mid-run reset", err_count, 0);

        // R10 and R3: fill with 8 bit errors per frame
        for (int i = 1; i <= 16400; i++) begin
            run_frame(1'b0, 32'(i), 8'hFF, 1'b1, 1'b0, 1'b0, 8'h00);
            if (i == 8000) check("R10 one second of bit errors", err_count, 64000);
        end
        check("R3 saturated", err_count, CMAX);
        run_frame(1'b1, 32'h0, 8'h01, 1'b1, 1'b0, 1'b0, 8'h00);
        check("R3 stays at max", err_count, CMAX);
        read_clear("R3 clear from max");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule